// File: doc/BRIEF.md
# Load-Store Ordering Guard

This block decides, cycle by cycle, whether a load may go to memory ahead of the stores that precede it in program order. Stores are entered into a circular queue when they are dispatched. Each store carries its reorder-buffer age, and its address arrives later, once the store's address phase completes. Its data phase is not seen here. A load is presented combinationally with its age, address and PC, and the block answers at once with a grant.

Two policies are selectable. In the cautious policy a load passes only when every older store has a resolved address and none of them collides with it. In the eager policy a load may pass stores whose address is still unknown. Such a load is remembered, and if an older store later resolves to a colliding address, the block raises a squash naming the oldest offending load. That load's PC is then marked in a small direct-mapped table. A marked load is held until no older store remains at all. The table is wiped at a fixed interval so that stale marks do not slow code down forever.

Addresses are compared only on their low bits, and a partial match counts as a collision. Ages are reorder-buffer indices with an extra wrap bit, so age order stays correct when the index rolls over.

Top module: `lsdc_unit`

## Requirements
- R1: Only stores strictly older than the load take part in its check. Age order uses the top bit of each age as a wrap flag: with equal flags the smaller index is older, with different flags the larger index is older.
- R2: With `spec_mode`=0 the grant is 1 only when every older queued store has a resolved address and none of those addresses collides with the load address.
- R3: Two addresses collide when their low CMP_W bits are equal (12 by default), whatever their upper bits.
- R4: The store queue holds SQ_DEPTH entries (16 by default). `sq_full` is 1 exactly when it holds that many. `st_commit_valid` removes the oldest store. After reset the queue is empty and `squash_valid` is 0.
- R5: With `spec_mode`=1 a load may pass older stores whose address is unknown. It is refused if an older store with a resolved colliding address is queued, or if an older store resolves to a colliding address in the same cycle.
- R6: A store address resolution that collides with one or more younger loads that passed it in the eager policy makes `squash_valid` 1 for exactly the next cycle. `squash_age` then holds the age of the oldest of those loads. A non-colliding resolution raises no squash.
- R7: On a squash, every queued store younger than the squashed load is dropped, and so is every tracked load not older than it.
- R8: A squash marks the squashed load's PC in a table of SW_ENTRIES one-bit entries indexed by PC bits [log2(SW_ENTRIES)+1:2]. A load whose index is marked is granted, in either policy, only when no older store is queued.
- R9: The whole table is cleared at the clock edge where a free-running counter, started at 0 by reset and advanced every cycle, equals CLEAR_PERIOD-1. A clear wins over a mark in the same edge.
- R10: Up to LQ_DEPTH eager loads that passed an unresolved store are tracked. While the tracker is full, passing an unresolved older store is refused. A tracked load is released once no store older than it remains queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_mode | input | 1 | 0 = cautious policy, 1 = eager policy |
| st_alloc_valid | input | 1 | Enter a store at the queue tail |
| st_alloc_age | input | AGE_W+1 | Age of the entered store |
| sq_full | output | 1 | Store queue holds SQ_DEPTH entries |
| st_addr_valid | input | 1 | A queued store's address has resolved |
| st_addr_age | input | AGE_W+1 | Age of the resolving store |
| st_addr | input | ADDR_W | Resolved store address |
| st_commit_valid | input | 1 | Remove the oldest queued store |
| ld_req_valid | input | 1 | A load asks to issue |
| ld_req_age | input | AGE_W+1 | Age of the load |
| ld_req_addr | input | ADDR_W | Load address |
| ld_req_pc | input | PC_W | Load PC |
| ld_grant | output | 1 | Load may issue this cycle |
| squash_valid | output | 1 | Ordering violation detected |
| squash_age | output | AGE_W+1 | Age of the oldest violating load |

## Verification
The bench builds the block with a 4-entry store queue, a 4-entry load tracker, a 3-bit reorder index plus wrap bit, a 4-bit address compare, an 8-entry mark table and a 64-cycle clear period. With these values both queues fill in a handful of operations, and the ages wrap within one test. A sweep over load addresses hits every low-nibble alias of a resolved store. The bench keeps its own cycle count, so it can place a probe on the very cycle before the table wipe and on the cycle after it.

// File: rtl/lsdc_pkg.sv
package lsdc_pkg;

    localparam int AGE_MAX = 16;

    typedef enum logic {
        MODE_CAUTIOUS = 1'b0,
        MODE_EAGER    = 1'b1
    } lsdc_mode_e;

    // True when age a precedes age b; bit w of each age is its wrap flag.
    function automatic logic age_older(input logic [AGE_MAX-1:0] a,
                                       input logic [AGE_MAX-1:0] b,
                                       input int unsigned w);
        logic [AGE_MAX-1:0] m;
        m = (AGE_MAX'(1) << w) - AGE_MAX'(1);
        if (a[w] == b[w]) return (a & m) < (b & m);
        return (a & m) > (b & m);
    endfunction

endpackage

// File: rtl/lsdc_store_queue.sv
module lsdc_store_queue
    import lsdc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AGE_W = 6,
    parameter int CMP_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_valid,
    input  logic [AGE_W:0]                  alloc_age,
    input  logic                            res_valid,
    input  logic [AGE_W:0]                  res_age,
    input  logic [CMP_W-1:0]                res_addr,
    input  logic                            commit_valid,
    input  logic                            squash_hit,
    input  logic [AGE_W:0]                  squash_age,
    output logic                            full,
    output logic [DEPTH-1:0]                ent_valid,
    output logic [DEPTH-1:0]                ent_known,
    output logic [DEPTH-1:0][AGE_W:0]       ent_age,
    output logic [DEPTH-1:0][CMP_W-1:0]     ent_addr
);
    // DEPTH must be a power of two: the pointers wrap by overflow.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]              head;
        logic [PTR_W-1:0]              tail;
        logic [CNT_W-1:0]              count;
        logic [DEPTH-1:0]              known;
        logic [DEPTH-1:0][AGE_W:0]     age;
        logic [DEPTH-1:0][CMP_W-1:0]   addr;
    } sq_state_t;

    sq_state_t        s_q, s_d;
    logic [PTR_W-1:0] off;
    logic [DEPTH-1:0] young;
    logic [CNT_W-1:0] n_young;

    always_comb begin
        off = '0;
        for (int i = 0; i < DEPTH; i++) begin
            off          = PTR_W'(i) - s_q.head;
            ent_valid[i] = CNT_W'(off) < s_q.count;
        end
    end

    assign full      = s_q.count == CNT_W'(DEPTH);
    assign ent_known = s_q.known;
    assign ent_age   = s_q.age;
    assign ent_addr  = s_q.addr;

    always_comb begin
        s_d   = s_q;
        young = '0;
        for (int i = 0; i < DEPTH; i++) begin
            young[i] = squash_hit & ent_valid[i] &
                       age_older(AGE_MAX'(squash_age), AGE_MAX'(s_q.age[i]), AGE_W);
            if (res_valid && ent_valid[i] && s_q.age[i] == res_age) begin
                s_d.known[i] = 1'b1;
                s_d.addr[i]  = res_addr;
            end
        end
        n_young = CNT_W'($countones(young));
        if (commit_valid && s_q.count != '0) begin
            s_d.head  = s_q.head + PTR_W'(1);
            s_d.count = s_d.count - CNT_W'(1);
        end
        s_d.tail  = s_d.tail - PTR_W'(n_young);
        s_d.count = s_d.count - n_young;
        if (alloc_valid && !full && !squash_hit) begin
            s_d.known[s_d.tail] = 1'b0;
            s_d.age[s_d.tail]   = alloc_age;
            s_d.tail            = s_d.tail + PTR_W'(1);
            s_d.count           = s_d.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    sq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(DEPTH));

endmodule

// File: rtl/lsdc_load_tracker.sv
module lsdc_load_tracker
    import lsdc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AGE_W = 6,
    parameter int CMP_W = 12,
    parameter int PCI_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rec_valid,
    input  logic [AGE_W:0]              rec_age,
    input  logic [CMP_W-1:0]            rec_addr,
    input  logic [PCI_W-1:0]            rec_pci,
    input  logic [DEPTH-1:0]            retire,
    input  logic                        res_valid,
    input  logic [AGE_W:0]              res_age,
    input  logic [CMP_W-1:0]            res_addr,
    output logic                        full,
    output logic [DEPTH-1:0]            ent_valid,
    output logic [DEPTH-1:0][AGE_W:0]   ent_age,
    output logic                        squash_hit,
    output logic [AGE_W:0]              squash_age_c,
    output logic [PCI_W-1:0]            squash_pci,
    output logic                        squash_valid,
    output logic [AGE_W:0]              squash_age
);
    localparam int SLOT_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]              valid;
        logic [DEPTH-1:0][AGE_W:0]     age;
        logic [DEPTH-1:0][CMP_W-1:0]   addr;
        logic [DEPTH-1:0][PCI_W-1:0]   pci;
        logic                          sq_v;
        logic [AGE_W:0]                sq_age;
    } lt_state_t;

    lt_state_t         s_q, s_d;
    logic [DEPTH-1:0]  hit, sel;
    logic [SLOT_W-1:0] slot;
    logic              rec_ok, young_left;

    assign full         = &s_q.valid;
    assign ent_valid    = s_q.valid;
    assign ent_age      = s_q.age;
    assign squash_valid = s_q.sq_v;
    assign squash_age   = s_q.sq_age;

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            hit[i] = s_q.valid[i] & res_valid & (s_q.addr[i] == res_addr) &
                     age_older(AGE_MAX'(res_age), AGE_MAX'(s_q.age[i]), AGE_W);
        squash_age_c = '0;
        squash_pci   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sel[i] = hit[i];
            for (int j = 0; j < DEPTH; j++)
                if (j != i && hit[j] &&
                    age_older(AGE_MAX'(s_q.age[j]), AGE_MAX'(s_q.age[i]), AGE_W))
                    sel[i] = 1'b0;
            squash_age_c = squash_age_c | ({(AGE_W+1){sel[i]}} & s_q.age[i]);
            squash_pci   = squash_pci   | ({PCI_W{sel[i]}} & s_q.pci[i]);
        end
        squash_hit = |hit;
    end

    always_comb begin
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!s_q.valid[i]) slot = SLOT_W'(i);
        rec_ok = rec_valid && !full &&
                 !(squash_hit && !age_older(AGE_MAX'(rec_age), AGE_MAX'(squash_age_c), AGE_W));
        s_d        = s_q;
        s_d.valid  = s_q.valid & ~retire;
        for (int i = 0; i < DEPTH; i++)
            if (squash_hit &&
                !age_older(AGE_MAX'(s_q.age[i]), AGE_MAX'(squash_age_c), AGE_W))
                s_d.valid[i] = 1'b0;
        if (rec_ok) begin
            s_d.valid[slot] = 1'b1;
            s_d.age[slot]   = rec_age;
            s_d.addr[slot]  = rec_addr;
            s_d.pci[slot]   = rec_pci;
        end
        s_d.sq_v   = squash_hit;
        s_d.sq_age = squash_age_c;
    end

    always_comb begin
        young_left = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            young_left = young_left | (s_q.valid[i] &
                !age_older(AGE_MAX'(s_q.age[i]), AGE_MAX'(s_q.sq_age), AGE_W));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    one_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R7
    purge_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sq_v |-> !young_left);

endmodule

// File: rtl/lsdc_wait_table.sv
module lsdc_wait_table #(
    parameter int ENTRIES = 64,
    parameter int PERIOD  = 16384
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_valid,
    input  logic [$clog2(ENTRIES)-1:0] set_idx,
    input  logic [$clog2(ENTRIES)-1:0] look_idx,
    output logic                       look_bit
);
    localparam int CNT_W = $clog2(PERIOD);

    typedef struct packed {
        logic [ENTRIES-1:0] bits;
        logic [CNT_W-1:0]   cnt;
    } wt_state_t;

    wt_state_t s_q, s_d;
    logic      tick;

    assign tick     = s_q.cnt == CNT_W'(PERIOD - 1);
    assign look_bit = s_q.bits[look_idx];

    always_comb begin
        s_d     = s_q;
        s_d.cnt = tick ? '0 : s_q.cnt + CNT_W'(1);
        if (set_valid) s_d.bits[set_idx] = 1'b1;
        if (tick)      s_d.bits = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> s_q.bits == '0);

endmodule

// File: rtl/lsdc_unit.sv
module lsdc_unit
    import lsdc_pkg::*;
#(
    parameter int SQ_DEPTH     = 16,
    parameter int LQ_DEPTH     = 16,
    parameter int AGE_W        = 6,
    parameter int ADDR_W       = 32,
    parameter int CMP_W        = 12,
    parameter int PC_W         = 32,
    parameter int SW_ENTRIES   = 64,
    parameter int CLEAR_PERIOD = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_mode,
    input  logic              st_alloc_valid,
    input  logic [AGE_W:0]    st_alloc_age,
    output logic              sq_full,
    input  logic              st_addr_valid,
    input  logic [AGE_W:0]    st_addr_age,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              st_commit_valid,
    input  logic              ld_req_valid,
    input  logic [AGE_W:0]    ld_req_age,
    input  logic [ADDR_W-1:0] ld_req_addr,
    input  logic [PC_W-1:0]   ld_req_pc,
    output logic              ld_grant,
    output logic              squash_valid,
    output logic [AGE_W:0]    squash_age
);
    localparam int PCI_W = $clog2(SW_ENTRIES);

    logic [SQ_DEPTH-1:0]              sq_valid, sq_known, older_st;
    logic [SQ_DEPTH-1:0][AGE_W:0]     sq_age;
    logic [SQ_DEPTH-1:0][CMP_W-1:0]   sq_addr;
    logic [LQ_DEPTH-1:0]              lq_valid, lq_retire;
    logic [LQ_DEPTH-1:0][AGE_W:0]     lq_age;
    logic                             lq_full, sq_hit;
    logic [AGE_W:0]                   hit_age;
    logic [PCI_W-1:0]                 hit_pci, ld_pci;
    logic [CMP_W-1:0]                 ld_lo;
    logic                             wait_bit, any_older, unk_older, match_older;
    logic                             res_block, grant_c, rec_valid;
    lsdc_mode_e                       mode;

    assign mode   = lsdc_mode_e'(spec_mode);
    assign ld_lo  = ld_req_addr[CMP_W-1:0];
    assign ld_pci = ld_req_pc[PCI_W+1:2];

    always_comb begin
        unk_older   = 1'b0;
        match_older = 1'b0;
        for (int i = 0; i < SQ_DEPTH; i++) begin
            older_st[i] = sq_valid[i] &
                age_older(AGE_MAX'(sq_age[i]), AGE_MAX'(ld_req_age), AGE_W);
            unk_older   = unk_older   | (older_st[i] & ~sq_known[i]);
            match_older = match_older | (older_st[i] & sq_known[i] & (sq_addr[i] == ld_lo));
        end
        any_older = |older_st;
        res_block = st_addr_valid && (st_addr[CMP_W-1:0] == ld_lo) &&
                    age_older(AGE_MAX'(st_addr_age), AGE_MAX'(ld_req_age), AGE_W);
        if (wait_bit)                  grant_c = !any_older;
        else if (mode == MODE_CAUTIOUS) grant_c = !unk_older && !match_older;
        else                           grant_c = !match_older && !res_block &&
                                                 (!unk_older || !lq_full);
        rec_valid = ld_req_valid && grant_c && (mode == MODE_EAGER) &&
                    unk_older && !wait_bit;
    end

    assign ld_grant = ld_req_valid & grant_c;

    always_comb begin
        for (int j = 0; j < LQ_DEPTH; j++) begin
            lq_retire[j] = 1'b1;
            for (int i = 0; i < SQ_DEPTH; i++)
                if (sq_valid[i] &&
                    age_older(AGE_MAX'(sq_age[i]), AGE_MAX'(lq_age[j]), AGE_W))
                    lq_retire[j] = 1'b0;
        end
    end

    lsdc_store_queue #(.DEPTH(SQ_DEPTH), .AGE_W(AGE_W), .CMP_W(CMP_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(st_alloc_valid), .alloc_age(st_alloc_age),
        .res_valid(st_addr_valid), .res_age(st_addr_age), .res_addr(st_addr[CMP_W-1:0]),
        .commit_valid(st_commit_valid),
        .squash_hit(sq_hit), .squash_age(hit_age),
        .full(sq_full), .ent_valid(sq_valid), .ent_known(sq_known),
        .ent_age(sq_age), .ent_addr(sq_addr)
    );

    lsdc_load_tracker #(.DEPTH(LQ_DEPTH), .AGE_W(AGE_W), .CMP_W(CMP_W), .PCI_W(PCI_W)) u_lt (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_age(ld_req_age), .rec_addr(ld_lo), .rec_pci(ld_pci),
        .retire(lq_retire),
        .res_valid(st_addr_valid), .res_age(st_addr_age), .res_addr(st_addr[CMP_W-1:0]),
        .full(lq_full), .ent_valid(lq_valid), .ent_age(lq_age),
        .squash_hit(sq_hit), .squash_age_c(hit_age), .squash_pci(hit_pci),
        .squash_valid(squash_valid), .squash_age(squash_age)
    );

    lsdc_wait_table #(.ENTRIES(SW_ENTRIES), .PERIOD(CLEAR_PERIOD)) u_wt (
        .clk(clk), .rst_n(rst_n),
        .set_valid(sq_hit), .set_idx(hit_pci),
        .look_idx(ld_pci), .look_bit(wait_bit)
    );

    // R10
    tracker_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&lq_valid) |=> !(&lq_valid) || $stable(lq_age) || $past(sq_hit) || $past(|lq_retire));

endmodule

// File: tb/tb_lsdc_unit.sv
module tb_lsdc_unit;
    localparam int AW = 3;

    logic              clk = 0, rst_n = 0, spec_mode = 0;
    logic              st_alloc_valid = 0, st_addr_valid = 0, st_commit_valid = 0, ld_req_valid = 0;
    logic [AW:0]       st_alloc_age = 0, st_addr_age = 0, ld_req_age = 0;
    logic [15:0]       st_addr = 0, ld_req_addr = 0, ld_req_pc = 0;
    logic              sq_full, ld_grant, squash_valid;
    logic [AW:0]       squash_age;
    int                nchk = 0, nerr = 0, cyc = 0;

    lsdc_unit #(.SQ_DEPTH(4), .LQ_DEPTH(4), .AGE_W(AW), .ADDR_W(16), .CMP_W(4),
                .PC_W(16), .SW_ENTRIES(8), .CLEAR_PERIOD(64)) dut (
        .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode),
        .st_alloc_valid(st_alloc_valid), .st_alloc_age(st_alloc_age), .sq_full(sq_full),
        .st_addr_valid(st_addr_valid), .st_addr_age(st_addr_age), .st_addr(st_addr),
        .st_commit_valid(st_commit_valid),
        .ld_req_valid(ld_req_valid), .ld_req_age(ld_req_age), .ld_req_addr(ld_req_addr),
        .ld_req_pc(ld_req_pc), .ld_grant(ld_grant),
        .squash_valid(squash_valid), .squash_age(squash_age)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic alloc(input logic [AW:0] a);
        st_alloc_valid = 1; st_alloc_age = a;
        @(negedge clk); st_alloc_valid = 0;
    endtask

    task automatic resolve(input logic [AW:0] a, input logic [15:0] ad);
        st_addr_valid = 1; st_addr_age = a; st_addr = ad;
        @(negedge clk); st_addr_valid = 0;
    endtask

    task automatic commit();
        st_commit_valid = 1;
        @(negedge clk); st_commit_valid = 0;
    endtask

    task automatic probe(input logic [AW:0] a, input logic [15:0] ad, input logic [15:0] pc,
                         input int exp, input string req);
        ld_req_valid = 1; ld_req_age = a; ld_req_addr = ad; ld_req_pc = pc;
        #1 chk(req, int'(ld_grant), exp);
        @(negedge clk); ld_req_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 reset squash", int'(squash_valid), 0);
        chk("R4 reset full", int'(sq_full), 0);
        probe(4'd0, 16'h0000, 16'h0, 1, "R1 empty queue");

        // cautious policy: ordering, resolution, partial compare
        alloc(4'd2);
        probe(4'd3, 16'h0123, 16'h0, 0, "R2 unknown older store");
        probe(4'd1, 16'h0123, 16'h0, 1, "R1 younger store ignored");
        resolve(4'd2, 16'h0123);
        for (int k = 0; k < 32; k++) begin
            logic [15:0] ad;
            ad = 16'(k * 37);
            probe(4'd3, ad, 16'h0, (ad[3:0] != 4'h3) ? 1 : 0, "R3 low-bit sweep");
        end
        probe(4'd3, 16'hA5C3, 16'h0, 0, "R3 alias upper bits");
        commit();
        probe(4'd3, 16'h0123, 16'h0, 1, "R4 commit empties");

        // capacity and age wrap
        alloc(4'd5); alloc(4'd6); alloc(4'd7);
        chk("R4 not full at 3", int'(sq_full), 0);
        alloc(4'd8);
        chk("R4 full at 4", int'(sq_full), 1);
        probe(4'd9, 16'h0055, 16'h0, 0, "R1 wrapped younger load");
        probe(4'd4, 16'h0055, 16'h0, 1, "R1 load older than all");
        probe(4'd6, 16'h0055, 16'h0, 0, "R2 one older unknown");
        resolve(4'd5, 16'h0011); resolve(4'd6, 16'h0022);
        resolve(4'd7, 16'h0033); resolve(4'd8, 16'h0044);
        probe(4'd9, 16'h0055, 16'h0, 1, "R2 all known no match");
        probe(4'd9, 16'h0104, 16'h0, 0, "R3 match across wrap");
        probe(4'd8, 16'h0044, 16'h0, 1, "R1 own age not older");
        commit();
        chk("R4 full clears", int'(sq_full), 0);
        commit(); commit(); commit();

        // eager policy, violation, training
        spec_mode = 1;
        while (cyc % 64 != 2) @(negedge clk);
        alloc(4'd10);
        probe(4'd11, 16'h0107, 16'h0014, 1, "R5 pass unknown store");
        probe(4'd12, 16'h0208, 16'h0008, 1, "R5 second pass");
        alloc(4'd13);
        resolve(4'd10, 16'h0F07);
        chk("R6 squash raised", int'(squash_valid), 1);
        chk("R6 squash age", int'(squash_age), 11);
        @(negedge clk);
        chk("R6 squash one cycle", int'(squash_valid), 0);
        spec_mode = 0;
        probe(4'd14, 16'h0009, 16'h0000, 1, "R7 younger store dropped");
        spec_mode = 1;
        probe(4'd14, 16'h0009, 16'h0054, 0, "R8 marked index waits");
        probe(4'd14, 16'h0009, 16'h0018, 1, "R8 unmarked index");
        spec_mode = 0;
        probe(4'd14, 16'h0009, 16'h0014, 0, "R8 waits in cautious");
        commit();
        spec_mode = 1;
        probe(4'd14, 16'h0009, 16'h0014, 1, "R8 nothing older");

        // periodic clear at the exact boundary
        alloc(4'd15);
        while (cyc % 64 != 63) @(negedge clk);
        probe(4'd0, 16'h0009, 16'h0014, 0, "R9 mark before wipe");
        probe(4'd0, 16'h0009, 16'h0014, 1, "R9 mark wiped");

        // same-cycle resolution, tracker capacity and release
        st_addr_valid = 1; st_addr_age = 4'd15; st_addr = 16'h0E05;
        probe(4'd1, 16'h0005, 16'h0020, 0, "R5 same-cycle collision");
        st_addr_valid = 0;
        chk("R6 no collision no squash", int'(squash_valid), 0);
        commit();
        alloc(4'd2);
        probe(4'd3, 16'h0001, 16'h0020, 1, "R10 track 1");
        probe(4'd4, 16'h0002, 16'h0020, 1, "R10 track 2");
        probe(4'd5, 16'h0003, 16'h0020, 1, "R10 track 3");
        probe(4'd6, 16'h0004, 16'h0020, 1, "R10 track 4");
        probe(4'd7, 16'h0006, 16'h0020, 0, "R10 tracker full");
        resolve(4'd2, 16'h00A0);
        chk("R6 clean resolve", int'(squash_valid), 0);
        commit();
        alloc(4'd8);
        probe(4'd10, 16'h0017, 16'h0020, 1, "R10 released slots");
        probe(4'd9, 16'h0027, 16'h0020, 1, "R10 second track");
        resolve(4'd8, 16'h0037);
        chk("R6 oldest raised", int'(squash_valid), 1);
        chk("R6 oldest age", int'(squash_age), 9);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule